// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block produces one instruction fetch address per cycle for a stream of fixed 16-bit instructions. It also holds the single-bit test flag that steers conditional branches. Each cycle a decoder presents three things: what kind of branch the current instruction is, its target, and any compare operation with its two operands. The sequencer then chooses the next fetch address. It supports unconditional branches that always run one delay-slot instruction, conditional branches that run a delay slot, and conditional branches that redirect immediately.

The `in_slot` output goes high while the delay-slot instruction is being fetched, so the decoder can tell that the instruction is a slot instruction. When an immediate conditional branch is taken, `kill` tells the pipeline to discard the sequential instruction that was already fetched. A stall input freezes all state without losing a branch that is still in progress.

Top module: `dbr_pc_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_addr` loads `rst_vector` with bit 0 cleared, `t_flag` clears to 0 and `in_slot` clears to 0.
- R2: In an unstalled cycle with no branch effect and `in_slot` low, `fetch_addr` advances by 2 at the next edge.
- R3: `br_kind` 1 is an unconditional delayed branch. The next fetch is `fetch_addr`+2 with `in_slot` high, and the fetch after that is the target.
- R4: `br_kind` 4 (taken when T=1) and `br_kind` 5 (taken when T=0) are delayed conditional branches. When taken they behave as in R3. When not taken they behave as in R2 and no slot follows.
- R5: `br_kind` 2 (taken when T=1) and `br_kind` 3 (taken when T=0) are immediate conditional branches. When taken, `kill` is high in that same cycle, the next fetch is the target, and `in_slot` stays low.
- R6: A branch kind from 1 to 5 presented while `in_slot` is high raises `slot_err` in that cycle and is ignored. The next fetch is the pending target.
- R7: `t_flag` changes only on a compare. `cmp_op` 1 sets T to (a==b), 2 sets T to signed a>b, 3 sets T to unsigned a>b, and 0 leaves T unchanged.
- R8: When a compare and a conditional branch arrive in the same cycle, the branch decides on the value of T from before that cycle's update.
- R9: Bit 0 of every branch target is forced to 0, so `fetch_addr` is always even.
- R10: While `stall` is high, `fetch_addr`, `t_flag` and `in_slot` hold, and `kill` and `slot_err` stay low. A pending slot redirect completes after the stall.
- R11: `br_kind` codes 6 and 7 have no branch effect and never raise `slot_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_vector | input | ADDR_W | Address loaded on reset |
| stall | input | 1 | Freezes all sequencer state |
| br_kind | input | 3 | Branch kind of the current instruction |
| br_target | input | ADDR_W | Branch target address |
| cmp_op | input | 2 | Compare operation selector |
| cmp_a | input | DATA_W | First compare operand |
| cmp_b | input | DATA_W | Second compare operand |
| fetch_addr | output | ADDR_W | Current fetch address |
| in_slot | output | 1 | Current fetch is a delay-slot instruction |
| kill | output | 1 | Discard the fetched sequential instruction |
| slot_err | output | 1 | A branch was placed in a delay slot |
| t_flag | output | 1 | Branch test flag |

## Verification
The hardest situations to reach are a branch landing in a delay slot while a stall arrives, and a compare that flips T in the same cycle as a conditional branch reads it. Directed sequences build each of these on purpose. Seeded random traffic then mixes stalls at about one cycle in eight with dense branch kinds, so that slots, stalls and compares overlap in many orders. A bench model derived from the requirements predicts every output.

// File: rtl/pcseq_pkg.sv
`timescale 1ns/1ps
package pcseq_pkg;

    typedef enum logic [2:0] {
        BK_NONE     = 3'd0,
        BK_JUMP     = 3'd1,
        BK_IF_T     = 3'd2,
        BK_IF_F     = 3'd3,
        BK_IF_T_DLY = 3'd4,
        BK_IF_F_DLY = 3'd5,
        BK_RSV6     = 3'd6,
        BK_RSV7     = 3'd7
    } br_kind_e;

    typedef enum logic [1:0] {
        CMP_NONE = 2'd0,
        CMP_EQ   = 2'd1,
        CMP_GT   = 2'd2,
        CMP_HI   = 2'd3
    } cmp_op_e;

    typedef struct packed {
        logic taken;
        logic delayed;
    } br_decision_t;

    localparam int INSN_BYTES = 2;

    function automatic logic is_branch(br_kind_e k);
        return (k == BK_JUMP) || (k == BK_IF_T) || (k == BK_IF_F) ||
               (k == BK_IF_T_DLY) || (k == BK_IF_F_DLY);
    endfunction

    function automatic logic is_delayed(br_kind_e k);
        return (k == BK_JUMP) || (k == BK_IF_T_DLY) || (k == BK_IF_F_DLY);
    endfunction

    function automatic logic cond_met(br_kind_e k, logic t);
        case (k)
            BK_JUMP:                  return 1'b1;
            BK_IF_T, BK_IF_T_DLY:     return t;
            BK_IF_F, BK_IF_F_DLY:     return ~t;
            default:                  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pcseq_tflag.sv
`timescale 1ns/1ps
module pcseq_tflag
    import pcseq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  cmp_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              t_q
);
    logic res;
    logic upd;

    always_comb begin
        case (op)
            CMP_EQ:  res = (a == b);
            CMP_GT:  res = ($signed(a) > $signed(b));
            CMP_HI:  res = (a > b);
            default: res = t_q;
        endcase
        upd = (op != CMP_NONE) && !stall;
    end

    always_ff @(posedge clk) begin
        if (rst)
            t_q <= 1'b0;
        else if (upd)
            t_q <= res;
    end

    assert_t_only_by_compare_R7: assert property (@(posedge clk) disable iff (rst)
        (op == CMP_NONE || stall) |=> $stable(t_q));

    assert_t_eq_result_R7: assert property (@(posedge clk) disable iff (rst)
        (op == CMP_EQ && !stall && a == b) |=> t_q);

endmodule

// File: rtl/pcseq_branch_eval.sv
`timescale 1ns/1ps
module pcseq_branch_eval
    import pcseq_pkg::*;
(
    input  br_kind_e      kind,
    input  logic          t_now,
    input  logic          in_slot,
    input  logic          stall,
    output br_decision_t  dec,
    output logic          kill,
    output logic          slot_err
);
    logic active;

    always_comb begin
        active      = !stall;
        dec.taken   = active && !in_slot && cond_met(kind, t_now);
        dec.delayed = is_delayed(kind);
        kill        = dec.taken && !dec.delayed;
        slot_err    = active && in_slot && is_branch(kind);
    end

endmodule

// File: rtl/pcseq_pc_reg.sv
`timescale 1ns/1ps
module pcseq_pc_reg
    import pcseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rst_vector,
    input  logic              stall,
    input  br_decision_t      dec,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc_q,
    output logic              slot_q
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(1);

    logic [ADDR_W-1:0] pend_q;
    logic [ADDR_W-1:0] tgt_even;

    assign tgt_even = target & ALIGN_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= rst_vector & ALIGN_MASK;
            slot_q <= 1'b0;
            pend_q <= '0;
        end else if (!stall) begin
            if (slot_q) begin
                pc_q   <= pend_q;
                slot_q <= 1'b0;
            end else if (dec.taken && dec.delayed) begin
                pc_q   <= pc_q + STEP;
                slot_q <= 1'b1;
                pend_q <= tgt_even;
            end else if (dec.taken) begin
                pc_q   <= tgt_even;
            end else begin
                pc_q   <= pc_q + STEP;
            end
        end
    end

    assert_stall_freezes_R10: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(pc_q) && $stable(slot_q)));

    assert_single_slot_R3: assert property (@(posedge clk) disable iff (rst)
        (slot_q && !stall) |=> !slot_q);

    assert_pc_even_R9: assert property (@(posedge clk) disable iff (rst)
        pc_q[0] == 1'b0);

endmodule

// File: rtl/dbr_pc_seq.sv
`timescale 1ns/1ps
module dbr_pc_seq
    import pcseq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rst_vector,
    input  logic              stall,
    input  logic [2:0]        br_kind,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [1:0]        cmp_op,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              in_slot,
    output logic              kill,
    output logic              slot_err,
    output logic              t_flag
);
    br_decision_t dec;
    br_kind_e     kind;
    cmp_op_e      op;

    assign kind = br_kind_e'(br_kind);
    assign op   = cmp_op_e'(cmp_op);

    pcseq_tflag #(.DATA_W(DATA_W)) u_tflag (
        .clk   (clk),
        .rst   (rst),
        .stall (stall),
        .op    (op),
        .a     (cmp_a),
        .b     (cmp_b),
        .t_q   (t_flag)
    );

    pcseq_branch_eval u_eval (
        .kind     (kind),
        .t_now    (t_flag),
        .in_slot  (in_slot),
        .stall    (stall),
        .dec      (dec),
        .kill     (kill),
        .slot_err (slot_err)
    );

    pcseq_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
        .clk        (clk),
        .rst        (rst),
        .rst_vector (rst_vector),
        .stall      (stall),
        .dec        (dec),
        .target     (br_target),
        .pc_q       (fetch_addr),
        .slot_q     (in_slot)
    );

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!stall && !in_slot && br_kind == 3'd0) |=>
            fetch_addr == $past(fetch_addr) + ADDR_W'(INSN_BYTES));

    assert_kill_no_slot_R5: assert property (@(posedge clk) disable iff (rst)
        (kill && !stall) |=> !in_slot);

    assert_err_not_kill_R6: assert property (@(posedge clk) disable iff (rst)
        !(kill && slot_err));

    assert_stall_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!kill && !slot_err));

endmodule

// File: tb/test_dbr_pc_seq.sv
`timescale 1ns/1ps
module test_dbr_pc_seq;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] rst_vector = 32'h0000_1001;
    logic          stall = 1'b0;
    logic [2:0]    br_kind = 3'd0;
    logic [AW-1:0] br_target = '0;
    logic [1:0]    cmp_op = 2'd0;
    logic [DW-1:0] cmp_a = '0;
    logic [DW-1:0] cmp_b = '0;
    logic [AW-1:0] fetch_addr;
    logic          in_slot, kill, slot_err, t_flag;

    int errors = 0;
    int checks = 0;

    logic [AW-1:0] m_pc, m_tgt;
    logic          m_slot, m_t;

    always #2 clk = ~clk;

    dbr_pc_seq #(.ADDR_W(AW), .DATA_W(DW)) i_dbr_pc_seq (
        .clk(clk), .rst(rst), .rst_vector(rst_vector), .stall(stall),
        .br_kind(br_kind), .br_target(br_target), .cmp_op(cmp_op),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .fetch_addr(fetch_addr),
        .in_slot(in_slot), .kill(kill), .slot_err(slot_err), .t_flag(t_flag)
    );

    function automatic logic f_cond(logic [2:0] k, logic t);
        case (k)
            3'd1:       return 1'b1;
            3'd2, 3'd4: return t;
            3'd3, 3'd5: return ~t;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic f_cmp(logic [1:0] op, logic [31:0] a, logic [31:0] b, logic t);
        case (op)
            2'd1:    return a == b;
            2'd2:    return $signed(a) > $signed(b);
            2'd3:    return a > b;
            default: return t;
        endcase
    endfunction

    function automatic string f_tag(logic [2:0] k, logic [1:0] op, logic st, logic slot);
        if (st) return "R10";
        if (slot && k >= 3'd1 && k <= 3'd5) return "R6";
        if (k >= 3'd6) return "R11";
        if (op != 2'd0 && k >= 3'd2 && k <= 3'd5) return "R8";
        if (k == 3'd1) return "R3";
        if (k == 3'd4 || k == 3'd5) return "R4";
        if (k == 3'd2 || k == 3'd3) return "R5";
        return "R2";
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(logic [2:0] k, logic [31:0] tg, logic [1:0] op,
                        logic [31:0] a, logic [31:0] b, logic st);
        logic e_take, e_err, e_kill, e_dly, act;
        string tag, ttag;
        br_kind = k; br_target = tg; cmp_op = op; cmp_a = a; cmp_b = b; stall = st;
        tag  = f_tag(k, op, st, m_slot);
        ttag = st ? "R10" : (k >= 3'd2 && k <= 3'd5) ? "R8" : "R7";
        #1;
        act    = !st;
        e_take = act && !m_slot && f_cond(k, m_t);
        e_dly  = (k == 3'd1) || (k == 3'd4) || (k == 3'd5);
        e_kill = e_take && !e_dly;
        e_err  = act && m_slot && (k >= 3'd1) && (k <= 3'd5);
        check(tag, "kill", 32'(kill), 32'(e_kill));
        check(tag, "slot_err", 32'(slot_err), 32'(e_err));
        if (act) begin
            m_t = f_cmp(op, a, b, m_t);
            if (m_slot) begin
                m_pc = m_tgt; m_slot = 1'b0;
            end else if (e_take && e_dly) begin
                m_pc = m_pc + 2; m_slot = 1'b1; m_tgt = tg & ~32'd1;
            end else if (e_take) begin
                m_pc = tg & ~32'd1;
            end else begin
                m_pc = m_pc + 2;
            end
        end
        @(negedge clk);
        check(tag, "fetch_addr", fetch_addr, m_pc);
        check(tag, "in_slot", 32'(in_slot), 32'(m_slot));
        check(ttag, "t_flag", 32'(t_flag), 32'(m_t));
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset loads the vector with bit 0 cleared (R9), T and slot clear
        check("R1", "fetch_addr", fetch_addr, 32'h0000_1000);
        check("R1", "t_flag", 32'(t_flag), 32'd0);
        check("R1", "in_slot", 32'(in_slot), 32'd0);
        m_pc = 32'h0000_1000; m_t = 1'b0; m_slot = 1'b0; m_tgt = '0;
        rst = 1'b0;

        // R2 sequential
        step(3'd0, 0, 2'd0, 0, 0, 1'b0);
        step(3'd0, 0, 2'd0, 0, 0, 1'b0);
        // R3 unconditional delayed, odd target (R9)
        step(3'd1, 32'h0000_2001, 2'd0, 0, 0, 1'b0);
        step(3'd0, 0, 2'd0, 0, 0, 1'b0);
        // R6 branch inside slot is ignored
        step(3'd1, 32'h0000_3000, 2'd0, 0, 0, 1'b0);
        step(3'd2, 32'h0000_3100, 2'd0, 0, 0, 1'b0);
        step(3'd0, 0, 2'd0, 0, 0, 1'b0);
        // R8 compare sets T while BT reads old T=0: not taken
        step(3'd2, 32'h0000_4000, 2'd1, 5, 5, 1'b0);
        // R5 immediate branch with T=1 is taken with kill
        step(3'd2, 32'h0000_4000, 2'd0, 0, 0, 1'b0);
        // R7 signed vs unsigned
        step(3'd0, 0, 2'd2, 32'hFFFF_FFFF, 32'd1, 1'b0);
        step(3'd0, 0, 2'd3, 32'hFFFF_FFFF, 32'd1, 1'b0);
        // R4 delayed BF with T=1 not taken, then BT/S taken
        step(3'd5, 32'h0000_5000, 2'd0, 0, 0, 1'b0);
        step(3'd4, 32'h0000_5000, 2'd0, 0, 0, 1'b0);
        // R10 stall during slot, then slot completes
        step(3'd1, 32'h0000_6000, 2'd1, 1, 2, 1'b1);
        step(3'd0, 0, 2'd0, 0, 0, 1'b0);
        // R11 reserved codes
        step(3'd6, 32'h0000_7000, 2'd0, 0, 0, 1'b0);
        step(3'd7, 32'h0000_7000, 2'd0, 0, 0, 1'b0);

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = ($urandom % 3 == 0) ? a : $urandom;
            step(3'($urandom % 8), $urandom, 2'($urandom % 4), a, b,
                 ($urandom % 8) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule